// File: doc/BRIEF.md
# Receive Word Buffer with Idle Timeout

This block sits between a serial receiver and a host data register. Each word the receiver assembles passes through one capture register and is then written into an eight-entry, sixteen-bit first-in first-out store. The host drains the store by pulsing a read request, and the oldest word appears on a registered read-data output in the next cycle.

The block raises three signals toward an interrupt block. A level-based service request stays high while four or more words are waiting. A one-cycle overrun pulse marks a word that found the store full and was thrown away. A one-cycle timeout pulse marks data that has waited for 32 serial-clock periods.

The timeout is counted on a serial-clock enable input, so it advances even when no transfer is taking place on the line. The count starts when the store goes from empty to holding data. It is not restarted by later arrivals, and it is cleared each time the store drains to empty.

Top module: `rxq_timeout_buffer`

## Requirements
- R1: After reset, `level` is 0, `rd_data` is 0, and `svc_req`, `tmo_evt` and `ovr_evt` are all 0.
- R2: A word sampled with `word_valid` at clock edge k is held in a capture register and written into storage at edge k+1. `level` therefore does not change at edge k and rises at edge k+1.
- R3: Words leave in arrival order. A `rd_req` sampled at an edge with `level` > 0 places the oldest word on `rd_data` after that edge, lowers `level` by one, and `rd_data` keeps that value until the next read.
- R4: The store holds 8 words of 16 bits, and `level` never exceeds 8.
- R5: If a captured word reaches the store while `level` is 8 and no read happens at the same edge, `ovr_evt` pulses high for exactly one cycle. The word is discarded, and the 8 stored words and `level` are unchanged. A read at the same edge makes room, and the word is then accepted.
- R6: `svc_req` is high exactly when `level` is 4 or more.
- R7: A `rd_req` while `level` is 0 sets `rd_data` to 0 and leaves `level` and the read order unchanged.
- R8: While `level` > 0, each clock edge with `sclk_tick` high advances a timeout count that started at 0 when the store became non-empty. At the 32nd such edge, `tmo_evt` pulses for exactly one cycle. The count then holds without pulsing again, and words written after the count has started do not restart it.
- R9: When `level` returns to 0, the timeout count is cleared. The next time the store becomes non-empty, a full 32 ticks are needed before `tmo_evt` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Assembled serial word is present this cycle |
| word_data | input | 16 | Assembled serial word |
| rd_req | input | 1 | Host read of the data register |
| sclk_tick | input | 1 | One-cycle enable per serial-clock period |
| rd_data | output | 16 | Word returned by the last read (0 if the store was empty) |
| level | output | 4 | Number of stored words, 0 to 8 |
| svc_req | output | 1 | Service request, high at four or more words |
| tmo_evt | output | 1 | One-cycle timeout event |
| ovr_evt | output | 1 | One-cycle overrun event |

## Verification
The bench targets the following corner cases:
- **Capture register.** It checks `level` in the cycle between capture and storage. A design without the capture register would show the word one cycle early.
- **Overrun.** It fills the store, pushes a ninth word, and then drains everything. A design that overwrote an entry or advanced its pointer on overrun would return the wrong words, or lose the oldest one.
- **Timeout window.** It counts spaced ticks one by one and requires the pulse on exactly the 32nd. A design that restarted the count on every arrival, pulsed repeatedly, or kept its count across a drain would pulse at the wrong tick.
- **Empty read.** It reads the store while empty. A design that moved its read pointer would return stale data afterwards.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_DATA_W = 16;
    localparam int unsigned RXQ_DEPTH  = 8;
    localparam int unsigned RXQ_TMO    = 32;

    // advance a circular index of a store with 'depth' entries
    function automatic int unsigned rxq_wrap_inc(input int unsigned idx, input int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rxq_capture.sv
module rxq_capture #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_data,
    output logic          cap_vld,
    output logic [DW-1:0] cap_data
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } cap_t;

    cap_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.vld  = in_vld;
        if (in_vld) begin
            s_d.data = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cap_vld  = s_q.vld;
    assign cap_data = s_q.data;

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          ovr_evt
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wptr;
        logic [PW-1:0]            rptr;
        logic [CW-1:0]            count;
        logic [DW-1:0]            rdata;
        logic                     ovr;
    } store_t;

    store_t s_d, s_q;
    logic   pop;
    logic   full;
    logic   accept;

    always_comb begin
        s_d     = s_q;
        s_d.ovr = 1'b0;
        full    = (s_q.count == CW'(DEPTH));
        pop     = rd_req && (s_q.count != '0);
        accept  = push && (!full || pop);

        if (pop) begin
            s_d.rdata = s_q.mem[s_q.rptr];
            s_d.rptr  = PW'(rxq_wrap_inc(int'(s_q.rptr), DEPTH));
        end else if (rd_req) begin
            s_d.rdata = '0;
        end

        if (accept) begin
            s_d.mem[s_q.wptr] = push_data;
            s_d.wptr          = PW'(rxq_wrap_inc(int'(s_q.wptr), DEPTH));
        end else if (push) begin
            s_d.ovr = 1'b1;
        end

        s_d.count = s_q.count + CW'(accept) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.rdata;
    assign count   = s_q.count;
    assign ovr_evt = s_q.ovr;

    // R4: occupancy stays within capacity
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= CW'(DEPTH));

    // R5: a word hitting a full store without a read is dropped and flagged
    a_r5_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (push && s_q.count == CW'(DEPTH) && !rd_req) |=> (s_q.ovr && s_q.count == CW'(DEPTH)));

    // R7: an empty read returns zero and leaves occupancy alone
    a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && s_q.count == '0 && !push) |=> (s_q.rdata == '0 && s_q.count == '0));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int unsigned CW  = 4,
    parameter int unsigned TMO = 32,
    localparam int unsigned TW = $clog2(TMO + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] level,
    output logic          tmo_evt
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          done;
        logic          evt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.evt = 1'b0;
        if (level == '0) begin
            s_d.cnt  = '0;
            s_d.done = 1'b0;
        end else if (tick && !s_q.done) begin
            if (s_q.cnt == TW'(TMO - 1)) begin
                s_d.evt  = 1'b1;
                s_d.done = 1'b1;
            end
            s_d.cnt = s_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tmo_evt = s_q.evt;

    // R8: the timeout event lasts a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.evt |=> !s_q.evt);

    // R9: an empty store never produces a timeout event
    a_r9_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |=> !s_q.evt);

endmodule

// File: rtl/rxq_timeout_buffer.sv
module rxq_timeout_buffer
    import rxq_pkg::*;
#(
    parameter int unsigned DATA_W    = RXQ_DATA_W,
    parameter int unsigned DEPTH     = RXQ_DEPTH,
    parameter int unsigned TMO_TICKS = RXQ_TMO,
    localparam int unsigned CW       = $clog2(DEPTH + 1),
    localparam int unsigned SVC_LVL  = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_data,
    input  logic              rd_req,
    input  logic              sclk_tick,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     level,
    output logic              svc_req,
    output logic              tmo_evt,
    output logic              ovr_evt
);
    logic              cap_vld;
    logic [DATA_W-1:0] cap_data;

    rxq_capture #(.DW(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (word_valid),
        .in_data  (word_data),
        .cap_vld  (cap_vld),
        .cap_data (cap_data)
    );

    rxq_store #(.DW(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cap_vld),
        .push_data (cap_data),
        .rd_req    (rd_req),
        .rd_data   (rd_data),
        .count     (level),
        .ovr_evt   (ovr_evt)
    );

    rxq_timer #(.CW(CW), .TMO(TMO_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sclk_tick),
        .level   (level),
        .tmo_evt (tmo_evt)
    );

    assign svc_req = (level >= CW'(SVC_LVL));

    // R2: without a captured word the occupancy cannot grow
    a_r2_no_growth_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_vld |=> (level <= $past(level)));

endmodule

// File: tb/tb_rxq_timeout_buffer.sv
`timescale 1ns/1ps
module tb_rxq_timeout_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        rd_req = 1'b0;
    logic        sclk_tick = 1'b0;
    logic [15:0] rd_data;
    logic [3:0]  level;
    logic        svc_req;
    logic        tmo_evt;
    logic        ovr_evt;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rxq_timeout_buffer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .rd_req     (rd_req),
        .sclk_tick  (sclk_tick),
        .rd_data    (rd_data),
        .level      (level),
        .svc_req    (svc_req),
        .tmo_evt    (tmo_evt),
        .ovr_evt    (ovr_evt)
    );

    // vector fields: [37:36] op (1 push, 2 read), [35:32] expected level,
    // [31:16] word pushed, [15:0] expected read data
    localparam int NV = 13;
    localparam logic [37:0] VEC [NV] = '{
        {2'd1, 4'd1, 16'h1111, 16'h0000},
        {2'd1, 4'd2, 16'h2222, 16'h0000},
        {2'd2, 4'd1, 16'h0000, 16'h1111},
        {2'd1, 4'd2, 16'h3333, 16'h0000},
        {2'd1, 4'd3, 16'h4444, 16'h0000},
        {2'd1, 4'd4, 16'h5555, 16'h0000},
        {2'd2, 4'd3, 16'h0000, 16'h2222},
        {2'd2, 4'd2, 16'h0000, 16'h3333},
        {2'd2, 4'd1, 16'h0000, 16'h4444},
        {2'd2, 4'd0, 16'h0000, 16'h5555},
        {2'd2, 4'd0, 16'h0000, 16'h0000},
        {2'd1, 4'd1, 16'hBEEF, 16'h0000},
        {2'd2, 4'd0, 16'h0000, 16'hBEEF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one cycle, idle one cycle, return at the sampling negedge
    task automatic step(input bit push, input bit rd, input logic [15:0] d);
        @(negedge clk);
        word_valid = push;
        word_data  = d;
        rd_req     = rd;
        @(negedge clk);
        word_valid = 1'b0;
        rd_req     = 1'b0;
        @(negedge clk);
    endtask

    // n serial ticks spaced four cycles apart; pulse expected on tick 'at' (0 = none)
    task automatic run_ticks(input string req, input int n, input int at);
        int pulses = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            sclk_tick = 1'b1;
            @(negedge clk);
            sclk_tick = 1'b0;
            check(req, {31'd0, tmo_evt}, {31'd0, (i == at)});
            if (tmo_evt) pulses++;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (tmo_evt) pulses++;
            end
        end
        check(req, pulses, (at != 0) ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 level", level, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 flags", {svc_req, tmo_evt, ovr_evt}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: capture register delays storage by one edge
        word_valid = 1'b1;
        word_data  = 16'h7E57;
        @(negedge clk);
        word_valid = 1'b0;
        check("R2 level before store", level, 0);
        @(negedge clk);
        check("R2 level after store", level, 1);
        step(1'b0, 1'b1, '0);
        check("R2 R3 data", rd_data, 16'h7E57);

        // R3 R6 R7 vector table
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][37:36] == 2'd1, VEC[v][37:36] == 2'd2, VEC[v][31:16]);
            check("R3 level", level, VEC[v][35:32]);
            check("R6 svc", svc_req, (VEC[v][35:32] >= 4));
            if (VEC[v][37:36] == 2'd2)
                check((VEC[v][15:0] == 0) ? "R7 empty read" : "R3 read data", rd_data, VEC[v][15:0]);
        end

        // R4 R5 fill, overrun, drain
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 16'hC000 + 16'(i));
        check("R4 full level", level, 8);
        check("R6 svc full", svc_req, 1);
        @(negedge clk);
        word_valid = 1'b1;
        word_data  = 16'hDEAD;
        @(negedge clk);
        word_valid = 1'b0;
        @(negedge clk);
        check("R5 ovr pulse", ovr_evt, 1);
        check("R5 level kept", level, 8);
        @(negedge clk);
        check("R5 ovr one cycle", ovr_evt, 0);
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b1, '0);
            check("R5 contents kept", rd_data, 16'hC000 + 16'(i));
        end
        check("R5 drained", level, 0);
        step(1'b0, 1'b1, '0);
        check("R7 read after drain", rd_data, 0);

        // R8 single pulse on tick 32, then hold
        step(1'b1, 1'b0, 16'h0A0A);
        run_ticks("R8 basic", 40, 32);
        step(1'b0, 1'b1, '0);
        // R8 later arrivals do not restart
        step(1'b1, 1'b0, 16'h0B0B);
        run_ticks("R8 first half", 16, 0);
        step(1'b1, 1'b0, 16'h0C0C);
        run_ticks("R8 no restart", 20, 16);
        step(1'b0, 1'b1, '0);
        step(1'b0, 1'b1, '0);
        check("R8 drained", level, 0);
        // R9 drain clears the count
        step(1'b1, 1'b0, 16'h0D0D);
        run_ticks("R9 partial", 20, 0);
        step(1'b0, 1'b1, '0);
        check("R9 empty", level, 0);
        step(1'b1, 1'b0, 16'h0E0E);
        run_ticks("R9 fresh count", 32, 32);
        step(1'b0, 1'b1, '0);
        check("R9 last data", rd_data, 16'h0E0E);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule